// File: doc/BRIEF.md
# Three-Mode Power State Controller

This controller decides which clocks run while the system is in its Run, Idle or Sleep power mode. Firmware asks for a low-power mode with one-cycle strobes. The controller then drops the processor and flash-interface clock enables in the cycle of the strobe, and it moves to the new mode on the next edge of the always-on slow clock. In Idle, the peripheral clock enables follow a snapshot of the firmware clock mask, taken at the edge where Idle began. In Sleep, every enable it drives is low, including the oscillator and the PLL. Only the slow clock that runs the controller itself stays alive.

Any of five reset sources returns the block to Run at once and without waiting for a clock edge. An interrupt or a wake-up input also ends a low-power mode. Idle returns straight to Run. Sleep first passes through a restart phase, in which only the oscillator is enabled, for a programmable number of slow-clock cycles. While a debugger is attached, every enable is forced high whatever the mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While any reset source is active (`rst_pin_n` low, or `rst_wdog`, `rst_lowv`, `rst_por`, `rst_dbgcmd` high), `mode_o` is 00 (Run), the CPU, flash, oscillator and PLL enables are 1, and `per_clk_en` equals `run_mask`. No clock edge is needed for this.
- R2: In Run (`mode_o`=00) with no request strobe, the CPU, flash, oscillator and PLL enables are 1 and `per_clk_en` follows `run_mask` combinationally (bit set = clock runs).
- R3: In Run, an accepted `idle_set` or `sleep_set` strobe drives `cpu_clk_en` and `fmi_clk_en` to 0 in the same cycle. `mode_o` becomes 01 (Idle) or 10 (Sleep) after the next edge.
- R4: In Idle, `cpu_clk_en`=`fmi_clk_en`=0 and oscillator and PLL stay on. `per_clk_en` equals the `run_mask` value sampled at the entry edge, and later changes of `run_mask` have no effect on it.
- R5: In Sleep, all enables (`cpu_clk_en`, `fmi_clk_en`, `per_clk_en`, `osc_en`, `pll_en`) are 0.
- R6: In Idle, `irq_pend` or `wake_in` high at an edge returns `mode_o` to 00 at that edge.
- R7: In Sleep, `irq_pend` or `wake_in` high moves to the restart phase (`mode_o`=11). In that phase only `osc_en` is 1. The phase lasts exactly L edges, where L is `settle_cnt` clamped to the range 16 to 1024, and the controller then returns to Run.
- R8: Any reset source asserted in Idle, Sleep or the restart phase returns `mode_o` to 00 immediately.
- R9: While `dbg_active` is 1, every enable output is 1 regardless of mode, and `mode_o` still reports the mode.
- R10: A request strobe in Run while `irq_pend` or `wake_in` is high is ignored: the clocks stay on and `mode_o` stays 00.
- R11: When `idle_set` and `sleep_set` arrive together, Sleep is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Always-on slow clock that runs the controller |
| rst_pin_n | input | 1 | External reset, active low |
| rst_wdog | input | 1 | Watchdog reset, active high |
| rst_lowv | input | 1 | Low-voltage reset, active high |
| rst_por | input | 1 | Power-up reset, active high |
| rst_dbgcmd | input | 1 | Debugger-issued reset, active high |
| idle_set | input | 1 | Firmware strobe requesting Idle |
| sleep_set | input | 1 | Firmware strobe requesting Sleep |
| irq_pend | input | 1 | Any interrupt pending |
| wake_in | input | 1 | Wake-up unit request |
| dbg_active | input | 1 | Debug session active; forces all enables on |
| run_mask | input | NPER | Firmware peripheral clock mask, 1 = run |
| settle_cnt | input | CW | Oscillator restart length in slow cycles |
| mode_o | output | 2 | 00 Run, 01 Idle, 10 Sleep, 11 restart |
| cpu_clk_en | output | 1 | Processor clock enable |
| fmi_clk_en | output | 1 | Flash-interface clock enable |
| per_clk_en | output | NPER | Peripheral clock enables |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
Some properties are checked on every cycle. Idle exits to Run one edge after a wake event, and Sleep moves to the restart phase. A pending event keeps Run from being left. In the restart phase only the oscillator is enabled, and the phase never runs past its maximum length. Debug keeps every enable high, and the peripheral enables do not move while Idle lasts. Other behaviour can only be shown by the bench's scenarios. These are the exact length of the restart phase at the clamp limits and between them, and the value of the Idle mask snapshot. They also include the same-cycle drop of the CPU enable on a strobe, the asynchronous return from each reset source, and the priority of Sleep over Idle.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NPER       = 8,
  parameter int SETTLE_MIN = 16,
  parameter int SETTLE_MAX = 1024,
  localparam int CW        = $clog2(SETTLE_MAX + 1)
) (
  input  logic            clk_rtc,
  input  logic            rst_pin_n,
  input  logic            rst_wdog,
  input  logic            rst_lowv,
  input  logic            rst_por,
  input  logic            rst_dbgcmd,
  input  logic            idle_set,
  input  logic            sleep_set,
  input  logic            irq_pend,
  input  logic            wake_in,
  input  logic            dbg_active,
  input  logic [NPER-1:0] run_mask,
  input  logic [CW-1:0]   settle_cnt,
  output logic [1:0]      mode_o,
  output logic            cpu_clk_en,
  output logic            fmi_clk_en,
  output logic [NPER-1:0] per_clk_en,
  output logic            osc_en,
  output logic            pll_en
);

  typedef enum logic [1:0] {M_RUN = 2'b00, M_IDLE = 2'b01, M_SLEEP = 2'b10, M_WAKE = 2'b11} mode_t;

  mode_t st, st_nx;
  logic [NPER-1:0] held;
  logic [CW-1:0]   cnt, lim;

  wire arst = !rst_pin_n | rst_wdog | rst_lowv | rst_por | rst_dbgcmd;
  wire evt  = irq_pend | wake_in;

  wire go_sleep = (st == M_RUN) && sleep_set && !evt;
  wire go_idle  = (st == M_RUN) && idle_set && !sleep_set && !evt;

  assign lim = (settle_cnt < CW'(SETTLE_MIN)) ? CW'(SETTLE_MIN) :
               (settle_cnt > CW'(SETTLE_MAX)) ? CW'(SETTLE_MAX) : settle_cnt;

  wire settle_done = (cnt == lim - 1'b1);

  always_comb begin
    st_nx = st;
    case (st)
      M_RUN:   if (go_sleep) st_nx = M_SLEEP; else if (go_idle) st_nx = M_IDLE;
      M_IDLE:  if (evt) st_nx = M_RUN;
      M_SLEEP: if (evt) st_nx = M_WAKE;
      M_WAKE:  if (settle_done) st_nx = M_RUN;
      default: st_nx = M_RUN;
    endcase
  end

  always_ff @(posedge clk_rtc or posedge arst) begin
    if (arst) begin
      st   <= M_RUN;
      held <= '0;
      cnt  <= '0;
    end else begin
      st <= st_nx;
      if (go_idle) held <= run_mask;
      if (st != M_WAKE) cnt <= '0;
      else if (!settle_done) cnt <= cnt + 1'b1;
    end
  end

  wire core_on = (st == M_RUN) && !go_sleep && !go_idle;

  assign mode_o     = st;
  assign cpu_clk_en = dbg_active | core_on;
  assign fmi_clk_en = dbg_active | core_on;
  assign osc_en     = dbg_active | (st != M_SLEEP);
  assign pll_en     = dbg_active | (st == M_RUN) | (st == M_IDLE);
  assign per_clk_en = {NPER{dbg_active}} |
                      ((st == M_RUN)  ? run_mask :
                       (st == M_IDLE) ? held : '0);

  logic            past_ok;
  logic [CW-1:0]   wk_cycles;

  always_ff @(posedge clk_rtc or posedge arst) begin
    if (arst) begin
      past_ok   <= 1'b0;
      wk_cycles <= '0;
    end else begin
      past_ok   <= 1'b1;
      wk_cycles <= (mode_o == 2'b11) ? wk_cycles + 1'b1 : '0;
    end
  end

  assert_idle_exit_R6: assert property (@(posedge clk_rtc) disable iff (arst)
    (mode_o == 2'b01 && evt) |=> (mode_o == 2'b00));

  assert_sleep_exit_R7: assert property (@(posedge clk_rtc) disable iff (arst)
    (mode_o == 2'b10 && evt) |=> (mode_o == 2'b11));

  assert_wake_only_osc_R7: assert property (@(posedge clk_rtc) disable iff (arst)
    (mode_o == 2'b11 && !dbg_active) |-> (osc_en && !cpu_clk_en && !pll_en && per_clk_en == '0));

  assert_wake_bound_R7: assert property (@(posedge clk_rtc) disable iff (arst)
    (mode_o == 2'b11) |-> (wk_cycles < CW'(SETTLE_MAX)));

  assert_pending_blocks_R10: assert property (@(posedge clk_rtc) disable iff (arst)
    (mode_o == 2'b00 && evt) |=> (mode_o == 2'b00));

  assert_debug_all_on_R9: assert property (@(posedge clk_rtc) disable iff (arst)
    dbg_active |-> (cpu_clk_en && fmi_clk_en && osc_en && pll_en && (&per_clk_en)));

  assert_sleep_dark_R5: assert property (@(posedge clk_rtc) disable iff (arst)
    (mode_o == 2'b10 && !dbg_active) |-> (!osc_en && !pll_en && !cpu_clk_en && per_clk_en == '0));

  assert_idle_mask_held_R4: assert property (@(posedge clk_rtc) disable iff (arst)
    (past_ok && mode_o == 2'b01 && $past(mode_o) == 2'b01 && !dbg_active && !$past(dbg_active))
      |-> $stable(per_clk_en));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_P = 10;
  localparam int NPER  = 8;
  localparam int CW    = 11;

  logic clk_rtc = 1'b0;
  logic rst_pin_n = 1'b1, rst_wdog = 1'b0, rst_lowv = 1'b0, rst_por = 1'b1, rst_dbgcmd = 1'b0;
  logic idle_set = 1'b0, sleep_set = 1'b0, irq_pend = 1'b0, wake_in = 1'b0, dbg_active = 1'b0;
  logic [NPER-1:0] run_mask = 8'hA5;
  logic [CW-1:0]   settle_cnt = '0;
  logic [1:0]      mode_o;
  logic            cpu_clk_en, fmi_clk_en, osc_en, pll_en;
  logic [NPER-1:0] per_clk_en;

  always #(CLK_P/2) clk_rtc = ~clk_rtc;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk_rtc, .rst_pin_n, .rst_wdog, .rst_lowv, .rst_por, .rst_dbgcmd,
    .idle_set, .sleep_set, .irq_pend, .wake_in, .dbg_active,
    .run_mask, .settle_cnt, .mode_o, .cpu_clk_en, .fmi_clk_en,
    .per_clk_en, .osc_en, .pll_en);

  int checks = 0, errors = 0;
  bit done = 0;
  string       tag_q[$];
  logic [13:0] exp_q[$];
  event        chk_ev;

  wire [13:0] obs = {mode_o, cpu_clk_en, fmi_clk_en, osc_en, pll_en, per_clk_en};

  function automatic logic [13:0] mk(logic [1:0] m, logic c, logic f, logic o, logic p, logic [7:0] pm);
    return {m, c, f, o, p, pm};
  endfunction

  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      string t;
      logic [13:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      checks++;
      if (obs !== e) begin
        errors++;
        $display("FAIL %s: got mode=%b cpu=%b fmi=%b osc=%b pll=%b per=%h, expected mode=%b cpu=%b fmi=%b osc=%b pll=%b per=%h",
                 t, obs[13:12], obs[11], obs[10], obs[9], obs[8], obs[7:0],
                 e[13:12], e[11], e[10], e[9], e[8], e[7:0]);
      end
    end
  end

  task automatic expect_v(string t, logic [13:0] e);
    #1;
    tag_q.push_back(t);
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_rtc);
    @(negedge clk_rtc);
  endtask

  task automatic sleep_cycle(logic [CW-1:0] s, int len, bit by_irq);
    sleep_set = 1'b1;
    step(1);
    sleep_set = 1'b0;
    expect_v("R5 sleep all off", mk(2'b10, 0, 0, 0, 0, 8'h00));
    settle_cnt = s;
    if (by_irq) irq_pend = 1'b1; else wake_in = 1'b1;
    step(1);
    irq_pend = 1'b0;
    wake_in  = 1'b0;
    expect_v("R7 restart entered", mk(2'b11, 0, 0, 1, 0, 8'h00));
    step(len - 1);
    expect_v("R7 restart last cycle", mk(2'b11, 0, 0, 1, 0, 8'h00));
    step(1);
    expect_v("R7 back to run", mk(2'b00, 1, 1, 1, 1, run_mask));
  endtask

  initial begin
    step(2);
    expect_v("R1 reset state", mk(2'b00, 1, 1, 1, 1, 8'hA5));
    rst_por = 1'b0;
    step(1);
    expect_v("R2 run clocks", mk(2'b00, 1, 1, 1, 1, 8'hA5));
    run_mask = 8'h3C;
    expect_v("R2 mask follows", mk(2'b00, 1, 1, 1, 1, 8'h3C));

    idle_set = 1'b1;
    expect_v("R3 idle strobe gates cpu", mk(2'b00, 0, 0, 1, 1, 8'h3C));
    step(1);
    idle_set = 1'b0;
    expect_v("R3 idle entered", mk(2'b01, 0, 0, 1, 1, 8'h3C));
    run_mask = 8'hFF;
    step(2);
    expect_v("R4 idle mask snapshot", mk(2'b01, 0, 0, 1, 1, 8'h3C));
    irq_pend = 1'b1;
    expect_v("R6 idle before edge", mk(2'b01, 0, 0, 1, 1, 8'h3C));
    step(1);
    irq_pend = 1'b0;
    expect_v("R6 idle exit irq", mk(2'b00, 1, 1, 1, 1, 8'hFF));

    idle_set = 1'b1; wake_in = 1'b1;
    expect_v("R10 strobe ignored", mk(2'b00, 1, 1, 1, 1, 8'hFF));
    step(1);
    expect_v("R10 stays run", mk(2'b00, 1, 1, 1, 1, 8'hFF));
    sleep_set = 1'b1;
    step(1);
    expect_v("R10 sleep ignored", mk(2'b00, 1, 1, 1, 1, 8'hFF));
    idle_set = 1'b0; sleep_set = 1'b0; wake_in = 1'b0;

    idle_set = 1'b1; step(1); idle_set = 1'b0;
    wake_in = 1'b1; step(1); wake_in = 1'b0;
    expect_v("R6 idle exit wake", mk(2'b00, 1, 1, 1, 1, 8'hFF));

    sleep_set = 1'b1;
    expect_v("R3 sleep strobe gates cpu", mk(2'b00, 0, 0, 1, 1, 8'hFF));
    sleep_set = 1'b0;
    sleep_cycle(11'd5,    16,   1'b0);
    sleep_cycle(11'd100,  100,  1'b1);
    sleep_cycle(11'd16,   16,   1'b1);
    sleep_cycle(11'd2000, 1024, 1'b0);
    sleep_cycle(11'd1024, 1024, 1'b1);

    idle_set = 1'b1; sleep_set = 1'b1;
    step(1);
    idle_set = 1'b0; sleep_set = 1'b0;
    expect_v("R11 sleep wins", mk(2'b10, 0, 0, 0, 0, 8'h00));
    dbg_active = 1'b1;
    expect_v("R9 debug in sleep", mk(2'b10, 1, 1, 1, 1, 8'hFF));
    dbg_active = 1'b0;
    rst_wdog = 1'b1;
    expect_v("R8 watchdog in sleep", mk(2'b00, 1, 1, 1, 1, 8'hFF));
    step(1); rst_wdog = 1'b0; step(1);

    run_mask = 8'h0F;
    idle_set = 1'b1; step(1); idle_set = 1'b0;
    run_mask = 8'h00;
    dbg_active = 1'b1;
    expect_v("R9 debug in idle", mk(2'b01, 1, 1, 1, 1, 8'hFF));
    dbg_active = 1'b0;
    expect_v("R4 idle mask after debug", mk(2'b01, 0, 0, 1, 1, 8'h0F));
    rst_pin_n = 1'b0;
    expect_v("R8 pin reset in idle", mk(2'b00, 1, 1, 1, 1, 8'h00));
    step(1); rst_pin_n = 1'b1; step(1);

    run_mask = 8'h81;
    sleep_set = 1'b1; step(1); sleep_set = 1'b0;
    settle_cnt = 11'd40;
    wake_in = 1'b1; step(1); wake_in = 1'b0;
    step(5);
    expect_v("R7 mid restart", mk(2'b11, 0, 0, 1, 0, 8'h00));
    rst_lowv = 1'b1;
    expect_v("R8 low-voltage in restart", mk(2'b00, 1, 1, 1, 1, 8'h81));
    step(1); rst_lowv = 1'b0; step(1);

    sleep_set = 1'b1; step(1); sleep_set = 1'b0;
    rst_dbgcmd = 1'b1;
    expect_v("R8 debug reset in sleep", mk(2'b00, 1, 1, 1, 1, 8'h81));
    step(1); rst_dbgcmd = 1'b0; step(1);
    rst_por = 1'b1;
    expect_v("R1 power-up reset", mk(2'b00, 1, 1, 1, 1, 8'h81));
    step(1); rst_por = 1'b0; step(1);

    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected run to end");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule